// File: doc/BRIEF.md
# Privilege-Gated Permission Overlay Register

This block holds a 64-bit overlay configuration made of sixteen 4-bit permission codes. Software reaches it through a system-register access port. Each request carries a 16-bit selector, a direction and, for writes, 64 bits of data. In the same cycle the block returns a one-hot outcome. The outcome is one of: the access is performed, the instruction is undefined, the access traps to privilege level 2, the access traps to privilege level 3, or the access is redirected to a slot in virtualization memory.

Which outcome applies depends on several inputs:
- the current privilege level;
- whether level 2 is enabled and whether level 3 is present;
- a handful of trap and enable control bits.

These are evaluated as a fixed-priority chain. A performed write updates the register on the next clock edge. A redirected access is handed to an external memory port at a fixed offset.

A second, independent lookup port takes a 4-bit field index. It returns the selected code and its decoded permissions: read, write, user execute, privileged execute, and the memory-read-only variants. When the overlay mechanism is switched off, the port raises a bypass flag.

Top module: `perm_overlay_reg`

## Requirements
- R1: A request produces a non-zero outcome only when req_valid is 1 and req_sel equals 16'hC515. That value is the concatenation op0=2'b11, op1=3'b000, CRn=4'b1010, CRm=4'b0010, op2=3'b101, with op0 in the most significant bits. Any other selector gives outcome 0 and leaves the register unchanged.
- R2: For a matching request, resp_outcome has exactly one bit set, in the same cycle as the request. The bits are: [4] ok, [3] undefined, [2] trap to level 2, [1] trap to level 3, [0] redirect.
- R3: A request at level 0 is undefined. A request at level 3 is always ok.
- R4: At level 1 the checks are applied in this order, and the first one that fires decides the outcome:
  - (a) undefined, if level 3 is present, l3_access_en is 0 and l3_undef_prio is 1;
  - (b) trap to level 2, if level 2 is enabled and the virtual-memory trap bit for this direction is 1 (vm_rd_trap for reads, vm_wr_trap for writes);
  - (c) trap to level 2, if level 2 is enabled, fg_impl is 1, either level 3 is absent or l3_fg_en is 1, and the fine-grained pass bit for this direction is 0 (fg_rd_pass or fg_wr_pass).
- R5: Otherwise, if level 3 is present with l3_access_en 0, the outcome is undefined when l3_undef is 1 and a trap to level 3 when it is 0. Whenever the outcome is a trap, resp_trap_class is 6'h18; in every other case it is 0.
- R6: The next check at level 1 is the redirect: nv_ctl[2] and nv_ctl[0] both 1 gives a redirect.
  - The redirect port then shows redir_valid=1 and redir_offset=12'h2B8. A write shows redir_write=1 with redir_wdata equal to req_wdata.
  - A read returns redir_rdata on resp_rdata.
  - The register is not changed.
- R7: At level 2, only the checks R4(a) and R5 apply; otherwise the request is ok. A level-2 request never traps to level 2 and is never redirected.
- R8: An ok read returns the register on resp_rdata. An ok write loads req_wdata on the next rising edge. A write with any other outcome leaves the register unchanged.
- R9: After reset the register is all zeros.
- R10: The lookup returns field m from bits [4m+3:4m]. Codes decode as follows:
  - 4'b0000 no access.
  - 4'b0010 memory-read-only; 4'b0011 adds lk_mro_tl[0]; 4'b0110 adds lk_mro_tl[1]; 4'b0111 sets both.
  - 4'b0100 write only.
  - 1xxx read, with bit 2 = write, bit 1 = privileged execute and bit 0 = user execute.
- R11: Codes 4'b0001 and 4'b0101 decode as no access: every permission output is 0.
- R12: With overlay_en 0, lk_bypass is 1 and lk_code together with all permission outputs is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 16 | Packed selector {op0,op1,CRn,CRm,op2} |
| req_wdata | input | 64 | Write data |
| cur_level | input | 2 | Current privilege level 0..3 |
| lvl2_enabled | input | 1 | Level 2 is enabled |
| lvl3_present | input | 1 | Level 3 is implemented |
| l3_undef_prio | input | 1 | Level-3 undefined condition with priority |
| l3_undef | input | 1 | Level-3 undefined condition |
| l3_access_en | input | 1 | Level-3 enable for this register |
| l3_fg_en | input | 1 | Level-3 enable for fine-grained traps |
| fg_impl | input | 1 | Fine-grained trapping implemented |
| vm_rd_trap | input | 1 | Virtual-memory read trap bit |
| vm_wr_trap | input | 1 | Virtual-memory write trap bit |
| fg_rd_pass | input | 1 | Fine-grained read pass (0 traps) |
| fg_wr_pass | input | 1 | Fine-grained write pass (0 traps) |
| nv_ctl | input | 3 | Nested-virtualization control |
| resp_outcome | output | 5 | One-hot {ok,undef,trap2,trap3,redirect} |
| resp_trap_class | output | 6 | Trap class, 6'h18 on a trap |
| resp_rdata | output | 64 | Read data |
| redir_valid | output | 1 | Access redirected to memory |
| redir_write | output | 1 | Redirected access is a write |
| redir_offset | output | 12 | Memory offset of the slot |
| redir_wdata | output | 64 | Data for a redirected write |
| redir_rdata | input | 64 | Memory data for a redirected read |
| lk_index | input | 4 | Lookup field index |
| overlay_en | input | 1 | Overlay mechanism enabled |
| lk_code | output | 4 | Selected field code |
| lk_read | output | 1 | Read permitted |
| lk_write | output | 1 | Write permitted |
| lk_uexec | output | 1 | User execute permitted |
| lk_pexec | output | 1 | Privileged execute permitted |
| lk_mro | output | 1 | Memory-read-only class |
| lk_mro_tl | output | 2 | Memory-read-only qualifiers |
| lk_bypass | output | 1 | Register ignored |

## Verification
The bench sweeps every level against every combination of the control bits in both directions, and compares each response with an ordered reference model.

The sweep is aimed at three corner cases:
- Priority inversions. Examples are a virtual-memory trap winning over the prioritised undefined condition, or a level-3 trap winning over a level-2 trap. A design that swapped these steps would report the wrong one-hot bit.
- Direction mix-ups. A design that used the read trap bit for writes would trap the wrong direction.
- A redirect applied at level 2, or one that also wrote the register. That would show up as a wrong outcome, or as a changed register on the next direct read.

Field-position, reserved-code and bypass tests catch slicing errors and reserved codes leaking permissions.

// File: rtl/povl_pkg.sv
package povl_pkg;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 16;
  localparam int REG_W      = FIELD_W * NUM_FIELDS;
  localparam int SEL_W      = 16;
  localparam int OC_W       = 5;
  localparam int OFS_W      = 12;
  localparam int CLASS_W    = 6;

  localparam logic [SEL_W-1:0]   SEL_MATCH  = {2'b11, 3'b000, 4'b1010, 4'b0010, 3'b101};
  localparam logic [OFS_W-1:0]   REDIR_OFS  = 12'h2B8;
  localparam logic [CLASS_W-1:0] TRAP_CLASS = 6'h18;

  localparam int OC_OK    = 4;
  localparam int OC_UNDEF = 3;
  localparam int OC_TRAP2 = 2;
  localparam int OC_TRAP3 = 1;
  localparam int OC_REDIR = 0;

  typedef struct packed {
    logic       lvl2_enabled;
    logic       lvl3_present;
    logic       l3_undef_prio;
    logic       l3_undef;
    logic       l3_access_en;
    logic       l3_fg_en;
    logic       fg_impl;
    logic       vm_rd_trap;
    logic       vm_wr_trap;
    logic       fg_rd_pass;
    logic       fg_wr_pass;
    logic [2:0] nv;
  } ctl_t;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ux;
    logic       px;
    logic       mro;
    logic [1:0] mro_tl;
  } perm_t;

  function automatic logic sel_matches(input logic [SEL_W-1:0] sel);
    return sel == SEL_MATCH;
  endfunction

  function automatic logic nv_redirects(input logic [2:0] nv);
    return nv[2] & nv[0];
  endfunction

  function automatic perm_t decode_code(input logic [FIELD_W-1:0] c);
    perm_t p;
    p = '0;
    if (c[3]) begin
      p.rd = 1'b1;
      p.wr = c[2];
      p.px = c[1];
      p.ux = c[0];
    end else if (c[1]) begin
      p.mro    = 1'b1;
      p.mro_tl = {c[2], c[0]};
    end else if (c == 4'b0100) begin
      p.wr = 1'b1;
    end
    return p;
  endfunction
endpackage

// File: rtl/povl_access_arbiter.sv
module povl_access_arbiter
  import povl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  logic                write,
  input  logic [SEL_W-1:0]    sel,
  input  logic [1:0]          level,
  input  ctl_t                ctl,
  output logic [OC_W-1:0]     outcome
);
  logic hit, gate_off, chk_prio_undef, vm_bit, fg_pass, fg_allowed;
  logic chk_vm_trap, chk_fg_trap, chk_nv;

  assign hit            = valid && sel_matches(sel);
  assign gate_off       = ctl.lvl3_present && !ctl.l3_access_en;
  assign chk_prio_undef = gate_off && ctl.l3_undef_prio;
  assign vm_bit         = write ? ctl.vm_wr_trap : ctl.vm_rd_trap;
  assign fg_pass        = write ? ctl.fg_wr_pass : ctl.fg_rd_pass;
  assign fg_allowed     = ctl.fg_impl && (!ctl.lvl3_present || ctl.l3_fg_en);
  assign chk_vm_trap    = ctl.lvl2_enabled && vm_bit;
  assign chk_fg_trap    = ctl.lvl2_enabled && fg_allowed && !fg_pass;
  assign chk_nv         = nv_redirects(ctl.nv);

  always_comb begin
    outcome = '0;
    if (hit) begin
      unique case (level)
        2'd0: outcome[OC_UNDEF] = 1'b1;
        2'd1: begin
          if (chk_prio_undef)   outcome[OC_UNDEF] = 1'b1;
          else if (chk_vm_trap) outcome[OC_TRAP2] = 1'b1;
          else if (chk_fg_trap) outcome[OC_TRAP2] = 1'b1;
          else if (gate_off)    outcome[ctl.l3_undef ? OC_UNDEF : OC_TRAP3] = 1'b1;
          else if (chk_nv)      outcome[OC_REDIR] = 1'b1;
          else                  outcome[OC_OK] = 1'b1;
        end
        2'd2: begin
          if (chk_prio_undef)   outcome[OC_UNDEF] = 1'b1;
          else if (gate_off)    outcome[ctl.l3_undef ? OC_UNDEF : OC_TRAP3] = 1'b1;
          else                  outcome[OC_OK] = 1'b1;
        end
        default: outcome[OC_OK] = 1'b1;
      endcase
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $countones(outcome) == 1);
  a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> outcome == '0);
  a_r3_level0: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && level == 2'd0) |-> outcome[OC_UNDEF]);
  a_r3_level3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && level == 2'd3) |-> outcome[OC_OK]);
  a_r4_prio_first: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && level == 2'd1 && chk_prio_undef) |-> outcome[OC_UNDEF]);
  a_r7_level2_scope: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && level == 2'd2) |-> !outcome[OC_TRAP2] && !outcome[OC_REDIR]);
  a_r5_gate_dominates_nv: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && gate_off && level != 2'd3) |-> !outcome[OC_OK] && !outcome[OC_REDIR]);
endmodule

// File: rtl/povl_field_store.sv
module povl_field_store
  import povl_pkg::*;
#(
  parameter int P_FIELD_W    = FIELD_W,
  parameter int P_NUM_FIELDS = NUM_FIELDS,
  localparam int W           = P_FIELD_W * P_NUM_FIELDS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < P_NUM_FIELDS; g++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)     q[g*P_FIELD_W +: P_FIELD_W] <= '0;
      else if (wr_en) q[g*P_FIELD_W +: P_FIELD_W] <= wdata[g*P_FIELD_W +: P_FIELD_W];
    end
  end

  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wdata));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));
  a_r9_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> q == '0);
endmodule

// File: rtl/povl_perm_decode.sv
module povl_perm_decode
  import povl_pkg::*;
#(
  parameter int P_FIELD_W    = FIELD_W,
  parameter int P_NUM_FIELDS = NUM_FIELDS,
  localparam int W           = P_FIELD_W * P_NUM_FIELDS,
  localparam int IDX_W       = $clog2(P_NUM_FIELDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [W-1:0]         regval,
  input  logic [IDX_W-1:0]     index,
  input  logic                 overlay_en,
  output logic [P_FIELD_W-1:0] code,
  output perm_t                perm,
  output logic                 bypass
);
  logic [P_FIELD_W-1:0] fields [P_NUM_FIELDS];
  logic [P_FIELD_W-1:0] picked;

  for (genvar g = 0; g < P_NUM_FIELDS; g++) begin : g_slice
    assign fields[g] = regval[g*P_FIELD_W +: P_FIELD_W];
  end

  assign picked = fields[index];
  assign bypass = !overlay_en;
  assign code   = bypass ? '0 : picked;
  assign perm   = bypass ? '0 : decode_code(picked);

  a_r11_reserved_none: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 4'b0001 || code == 4'b0101) |-> perm == '0);
  a_r12_bypass_silent: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (perm == '0 && code == '0));
  a_r10_exec_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (perm.ux || perm.px) |-> perm.rd);
endmodule

// File: rtl/perm_overlay_reg.sv
module perm_overlay_reg
  import povl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [SEL_W-1:0]    req_sel,
  input  logic [REG_W-1:0]    req_wdata,
  input  logic [1:0]          cur_level,
  input  logic                lvl2_enabled,
  input  logic                lvl3_present,
  input  logic                l3_undef_prio,
  input  logic                l3_undef,
  input  logic                l3_access_en,
  input  logic                l3_fg_en,
  input  logic                fg_impl,
  input  logic                vm_rd_trap,
  input  logic                vm_wr_trap,
  input  logic                fg_rd_pass,
  input  logic                fg_wr_pass,
  input  logic [2:0]          nv_ctl,
  output logic [OC_W-1:0]     resp_outcome,
  output logic [CLASS_W-1:0]  resp_trap_class,
  output logic [REG_W-1:0]    resp_rdata,
  output logic                redir_valid,
  output logic                redir_write,
  output logic [OFS_W-1:0]    redir_offset,
  output logic [REG_W-1:0]    redir_wdata,
  input  logic [REG_W-1:0]    redir_rdata,
  input  logic [3:0]          lk_index,
  input  logic                overlay_en,
  output logic [FIELD_W-1:0]  lk_code,
  output logic                lk_read,
  output logic                lk_write,
  output logic                lk_uexec,
  output logic                lk_pexec,
  output logic                lk_mro,
  output logic [1:0]          lk_mro_tl,
  output logic                lk_bypass
);
  ctl_t             ctl;
  logic [REG_W-1:0] reg_q;
  logic             store_wr;
  perm_t            perm;

  assign ctl = '{lvl2_enabled: lvl2_enabled, lvl3_present: lvl3_present,
                 l3_undef_prio: l3_undef_prio, l3_undef: l3_undef,
                 l3_access_en: l3_access_en, l3_fg_en: l3_fg_en, fg_impl: fg_impl,
                 vm_rd_trap: vm_rd_trap, vm_wr_trap: vm_wr_trap,
                 fg_rd_pass: fg_rd_pass, fg_wr_pass: fg_wr_pass, nv: nv_ctl};

  povl_access_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .valid(req_valid), .write(req_write),
    .sel(req_sel), .level(cur_level), .ctl(ctl), .outcome(resp_outcome)
  );

  assign store_wr = resp_outcome[OC_OK] && req_write;

  povl_field_store #(.P_FIELD_W(FIELD_W), .P_NUM_FIELDS(NUM_FIELDS)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(store_wr), .wdata(req_wdata), .q(reg_q)
  );

  povl_perm_decode #(.P_FIELD_W(FIELD_W), .P_NUM_FIELDS(NUM_FIELDS)) u_dec (
    .clk(clk), .rst_n(rst_n), .regval(reg_q), .index(lk_index),
    .overlay_en(overlay_en), .code(lk_code), .perm(perm), .bypass(lk_bypass)
  );

  assign lk_read   = perm.rd;
  assign lk_write  = perm.wr;
  assign lk_uexec  = perm.ux;
  assign lk_pexec  = perm.px;
  assign lk_mro    = perm.mro;
  assign lk_mro_tl = perm.mro_tl;

  assign redir_valid  = resp_outcome[OC_REDIR];
  assign redir_write  = redir_valid && req_write;
  assign redir_offset = REDIR_OFS;
  assign redir_wdata  = req_wdata;

  assign resp_trap_class = (resp_outcome[OC_TRAP2] || resp_outcome[OC_TRAP3]) ? TRAP_CLASS : '0;

  always_comb begin
    resp_rdata = '0;
    if (!req_write) begin
      if (resp_outcome[OC_OK])         resp_rdata = reg_q;
      else if (resp_outcome[OC_REDIR]) resp_rdata = redir_rdata;
    end
  end

  a_r6_redirect_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && req_write) |=> $stable(reg_q));
  a_r8_nonok_write_keeps_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_write && !resp_outcome[OC_OK]) |=> $stable(reg_q));
  a_r5_class_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_outcome[OC_TRAP2] || resp_outcome[OC_TRAP3]) |-> resp_trap_class == 6'h18);
endmodule

// File: tb/tb_perm_overlay_reg.sv
`timescale 1ns/1ps
module tb_perm_overlay_reg;
  localparam logic [15:0] SEL_OK = 16'hC515;
  localparam logic [63:0] MEMVAL = 64'hC0DE_0000_2B80_1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_sel = SEL_OK;
  logic [63:0] req_wdata = '0;
  logic [1:0]  cur_level = 2'd3;
  logic lvl2_enabled = 0, lvl3_present = 0, l3_undef_prio = 0, l3_undef = 0;
  logic l3_access_en = 1, l3_fg_en = 0, fg_impl = 0, vm_rd_trap = 0, vm_wr_trap = 0;
  logic fg_rd_pass = 1, fg_wr_pass = 1;
  logic [2:0]  nv_ctl = '0;
  logic [4:0]  resp_outcome;
  logic [5:0]  resp_trap_class;
  logic [63:0] resp_rdata, redir_wdata;
  logic [63:0] redir_rdata = MEMVAL;
  logic        redir_valid, redir_write;
  logic [11:0] redir_offset;
  logic [3:0]  lk_index = '0;
  logic        overlay_en = 1'b1;
  logic [3:0]  lk_code;
  logic lk_read, lk_write, lk_uexec, lk_pexec, lk_mro, lk_bypass;
  logic [1:0]  lk_mro_tl;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [63:0] model_reg = '0;

  always #2 clk = ~clk;

  perm_overlay_reg dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [4:0] E_OK = 5'b10000, E_UD = 5'b01000, E_T2 = 5'b00100,
                         E_T3 = 5'b00010, E_RD = 5'b00001;

  function automatic logic [4:0] ref_outcome(input logic [1:0] lv, input logic wr);
    logic off;
    if (!req_valid || req_sel != SEL_OK) return 5'b0;
    if (lv == 2'd0) return E_UD;
    if (lv == 2'd3) return E_OK;
    off = lvl3_present && !l3_access_en;
    if (off && l3_undef_prio) return E_UD;
    if (lv == 2'd1) begin
      if (lvl2_enabled && (wr ? vm_wr_trap : vm_rd_trap)) return E_T2;
      if (lvl2_enabled && fg_impl && (!lvl3_present || l3_fg_en) &&
          !(wr ? fg_wr_pass : fg_rd_pass)) return E_T2;
    end
    if (off) return l3_undef ? E_UD : E_T3;
    if (lv == 2'd1 && nv_ctl[2] && nv_ctl[0]) return E_RD;
    return E_OK;
  endfunction

  // {rd,wr,ux,px,mro,tl[1:0]} for every code
  function automatic logic [6:0] ref_perm(input logic [3:0] c);
    case (c)
      4'h0, 4'h1, 4'h5: return 7'b0000000;
      4'h2: return 7'b0000100;
      4'h3: return 7'b0000101;
      4'h6: return 7'b0000110;
      4'h7: return 7'b0000111;
      4'h4: return 7'b0100000;
      4'h8: return 7'b1000000;
      4'h9: return 7'b1010000;
      4'hA: return 7'b1001000;
      4'hB: return 7'b1011000;
      4'hC: return 7'b1100000;
      4'hD: return 7'b1110000;
      4'hE: return 7'b1101000;
      default: return 7'b1111000;
    endcase
  endfunction

  function automatic logic [127:0] lk_bundle();
    return {116'd0, lk_bypass, lk_code, lk_read, lk_write, lk_uexec, lk_pexec, lk_mro, lk_mro_tl};
  endfunction

  task automatic set_open();
    cur_level = 2'd3; lvl2_enabled = 0; lvl3_present = 0; l3_undef_prio = 0; l3_undef = 0;
    l3_access_en = 1; l3_fg_en = 0; fg_impl = 0; vm_rd_trap = 0; vm_wr_trap = 0;
    fg_rd_pass = 1; fg_wr_pass = 1; nv_ctl = 0; req_sel = SEL_OK;
  endtask

  task automatic do_write(input logic [63:0] d);
    @(negedge clk);
    set_open(); req_valid = 1; req_write = 1; req_wdata = d;
    @(posedge clk);
    @(negedge clk); req_valid = 0; req_write = 0;
    model_reg = d;
  endtask

  task automatic direct_read(input string req, input logic [63:0] exp);
    @(negedge clk);
    set_open(); req_valid = 1; req_write = 0;
    #1 chk(req, {59'd0, resp_outcome, resp_rdata}, {59'd0, E_OK, exp});
    req_valid = 0;
  endtask

  task automatic t_reset();
    direct_read("R9 reset value", 64'd0);
    @(negedge clk); overlay_en = 1;
    for (int i = 0; i < 16; i++) begin
      lk_index = 4'(i);
      #1 chk("R9 reset lookup", lk_bundle(), {116'd0, 1'b0, 4'd0, 7'd0});
    end
  endtask

  task automatic t_selector();
    do_write(64'h1111_2222_3333_4444);
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      set_open(); req_valid = 1; req_write = 1; req_wdata = '1;
      req_sel = SEL_OK ^ (16'd1 << b);
      #1 chk("R1 mismatched selector outcome", {123'd0, resp_outcome}, 128'd0);
      @(posedge clk);
    end
    @(negedge clk); req_valid = 0; req_sel = SEL_OK; req_write = 0;
    direct_read("R1 mismatched writes ignored", 64'h1111_2222_3333_4444);
    @(negedge clk); set_open(); req_valid = 0; req_write = 1;
    #1 chk("R1 invalid request idle", {123'd0, resp_outcome}, 128'd0);
    req_write = 0;
  endtask

  task automatic t_sweep();
    for (int lv = 0; lv < 4; lv++) begin
      for (int i = 0; i < 8192; i++) begin
        for (int wr = 0; wr < 2; wr++) begin
          logic [4:0] eo;
          logic [5:0] ec;
          logic [63:0] ed;
          @(negedge clk);
          cur_level = 2'(lv);
          lvl2_enabled = i[0]; lvl3_present = i[1]; l3_undef_prio = i[2]; l3_undef = i[3];
          l3_access_en = i[4]; l3_fg_en = i[5]; fg_impl = i[6]; vm_rd_trap = i[7];
          vm_wr_trap = i[8]; fg_rd_pass = i[9]; fg_wr_pass = i[10];
          nv_ctl = {i[11], i[11] ^ i[5], i[12]};
          req_sel = SEL_OK; req_valid = 1; req_write = wr[0];
          req_wdata = {32'(i * 7 + lv), 32'(i ^ 32'h5A5A_0F0F)};
          eo = ref_outcome(2'(lv), wr[0]);
          ec = (eo == E_T2 || eo == E_T3) ? 6'h18 : 6'h00;
          ed = '0;
          if (!wr[0] && eo == E_OK) ed = model_reg;
          if (!wr[0] && eo == E_RD) ed = MEMVAL;
          #1 chk("R2 R3 R4 R5 R6 R7 R8 sweep", {53'd0, resp_outcome, resp_trap_class, resp_rdata},
                 {53'd0, eo, ec, ed});
          @(posedge clk);
          if (wr[0] && eo == E_OK) model_reg = req_wdata;
        end
      end
    end
    @(negedge clk); req_valid = 0; req_write = 0;
    direct_read("R8 register after sweep", model_reg);
  endtask

  task automatic t_priority();
    // R4: undefined-priority beats the virtual-memory trap
    @(negedge clk); set_open(); cur_level = 1; req_valid = 1; req_write = 0;
    lvl3_present = 1; l3_access_en = 0; l3_undef_prio = 1; lvl2_enabled = 1; vm_rd_trap = 1;
    #1 chk("R4 prio undef over trap2", {123'd0, resp_outcome}, {123'd0, E_UD});
    // R5: trap to level 2 beats the level-3 trap
    l3_undef_prio = 0; vm_rd_trap = 0; fg_impl = 1; l3_fg_en = 1; fg_rd_pass = 0;
    #1 chk("R5 trap2 over trap3", {117'd0, resp_outcome, resp_trap_class}, {117'd0, E_T2, 6'h18});
    fg_rd_pass = 1;
    #1 chk("R5 trap3 class", {117'd0, resp_outcome, resp_trap_class}, {117'd0, E_T3, 6'h18});
    req_valid = 0;
  endtask

  task automatic t_redirect();
    do_write(64'hAAAA_BBBB_CCCC_DDDD);
    @(negedge clk); set_open(); cur_level = 1; nv_ctl = 3'b101; req_valid = 1; req_write = 0;
    #1 chk("R6 redirect read", {50'd0, resp_outcome, redir_valid, redir_write, redir_offset, resp_rdata},
           {50'd0, E_RD, 1'b1, 1'b0, 12'h2B8, MEMVAL});
    req_write = 1; req_wdata = 64'h0BAD_F00D_0000_0001;
    #1 chk("R6 redirect write", {64'd0, redir_wdata}, {64'd0, 64'h0BAD_F00D_0000_0001});
    chk("R6 redirect write strobe", {126'd0, redir_valid, redir_write}, {126'd0, 2'b11});
    @(posedge clk);
    @(negedge clk); req_valid = 0; req_write = 0;
    direct_read("R6 register untouched", 64'hAAAA_BBBB_CCCC_DDDD);
    @(negedge clk); set_open(); cur_level = 2; nv_ctl = 3'b111; req_valid = 1;
    #1 chk("R7 no redirect at level 2", {123'd0, resp_outcome}, {123'd0, E_OK});
    req_valid = 0;
  endtask

  task automatic t_lookup(input logic [63:0] pat);
    do_write(pat);
    @(negedge clk); overlay_en = 1;
    for (int m = 0; m < 16; m++) begin
      logic [3:0] c;
      c = pat[4*m +: 4];
      lk_index = 4'(m);
      #1 chk("R10 lookup field decode", lk_bundle(), {116'd0, 1'b0, c, ref_perm(c)});
    end
  endtask

  task automatic t_reserved();
    do_write(64'h0000_0000_0000_0051);
    @(negedge clk);
    lk_index = 0; #1 chk("R11 reserved 0001", lk_bundle(), {116'd0, 1'b0, 4'h1, 7'd0});
    lk_index = 1; #1 chk("R11 reserved 0101", lk_bundle(), {116'd0, 1'b0, 4'h5, 7'd0});
  endtask

  task automatic t_bypass();
    do_write(64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); overlay_en = 0;
    for (int m = 0; m < 16; m += 5) begin
      lk_index = 4'(m);
      #1 chk("R12 bypass forced", lk_bundle(), {116'd0, 1'b1, 4'd0, 7'd0});
    end
    overlay_en = 1;
    #1 chk("R12 bypass released", lk_bundle(), {116'd0, 1'b0, 4'hF, 7'b1111000});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_selector();
    t_priority();
    t_redirect();
    t_lookup(64'hFEDC_BA98_7654_3210);
    t_lookup(64'h0123_4567_89AB_CDEF);
    t_reserved();
    t_bypass();
    t_sweep();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule